// File: doc/BRIEF.md
# Double-Data-Rate Sample Output Formatter

This block sits between a converter core and the chip's output pads. Once per sample period it takes one converter word and an over-range flag. It then presents them either on a narrow set of double-data-rate lanes with a forwarded clock, or on a full-width single-data-rate parallel bus with its own forwarded clock. The block runs on one fast clock. A phase counter divides that clock into sample periods of `2*HALF` steps. The forwarded clock is made as a window of those steps, so each of its edges can be moved by whole steps.

In lane mode, lane `i` carries sample bits `2i` and `2i+1`. The even bit is held for the first half of the period and the odd bit for the second half. The forwarded clock rises in the middle of the even window and falls in the middle of the odd window, so a receiver captures the even bit on the rising edge and the odd bit on the falling edge. The sample, the interface mode, the edge shifts and the output-off control are all latched together at the sample boundary. Every period is therefore internally consistent.

Top module: `ddr_sample_fmt`

## Requirements
- R1: From reset until the end of the first full sample period, every output is 0 and both `lane_oe` and `par_oe` are low.
- R2: A sample period lasts `2*HALF` clock cycles, with phases numbered 0 to `2*HALF-1`. `cap_strobe` is high only in the last phase. The input word, the over-range flag and every configuration input are captured at the clock edge that ends that phase.
- R3: In lane mode (`lane_oe`=1), `lane_q[i]` carries bit `2i` during phases 0 to `HALF-1` and bit `2i+1` during phases `HALF` to `2*HALF-1`. With SAMPLE_W=14 there are 7 lanes. In this mode `par_q`, `par_ovr` and `par_clk` stay 0.
- R4: In lane mode with no edge shift, `lane_clk` is high from phase `HALF/2` up to, but not including, phase `HALF+HALF/2`. The even bit is therefore valid at the rising edge and the odd bit at the falling edge.
- R5: When its enable is set, each 3-bit two's-complement edge field moves its edge by that many phases. A positive value moves the edge later. When the enable is clear, the field has no effect.
- R6: Edge field values outside -2..+2 saturate: 3 acts as +2, and -3 or -4 act as -2.
- R7: In parallel mode (`par_oe`=1), `par_q` equals the whole sample and `par_ovr` equals the over-range flag for the entire period. `par_clk` is high from phase `HALF`+rise shift up to phase 0+fall shift, taken modulo `2*HALF`. The lane outputs stay 0.
- R8: Parallel mode is selected by `cfg_par` when `cfg_mode_src`=1, and by `strap_par` when `cfg_mode_src`=0.
- R9: With `cfg_out_off`=1 latched, all data and clock outputs are 0 and both enables are low for the whole period.
- R10: Input and configuration changes made in the middle of a period have no effect on that period's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast step clock, `2*HALF` steps per sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | SAMPLE_W | Converter sample word |
| smp_ovr | input | 1 | Over-range flag for the sample |
| cap_strobe | output | 1 | High in the last phase of a period; inputs are taken at its closing edge |
| strap_par | input | 1 | Strap input selecting parallel mode |
| cfg_mode_src | input | 1 | 1: mode taken from `cfg_par`; 0: mode taken from `strap_par` |
| cfg_par | input | 1 | Register mode bit (1 = parallel) |
| cfg_rise_en | input | 1 | Enables the rising-edge shift |
| cfg_rise_pos | input | 3 | Signed rising-edge shift in steps |
| cfg_fall_en | input | 1 | Enables the falling-edge shift |
| cfg_fall_pos | input | 3 | Signed falling-edge shift in steps |
| cfg_out_off | input | 1 | Disables all outputs |
| lane_q | output | SAMPLE_W/2 | Double-data-rate bit-pair lanes |
| lane_clk | output | 1 | Forwarded clock for the lanes |
| lane_oe | output | 1 | Lane drivers enabled |
| par_q | output | SAMPLE_W | Parallel data bus |
| par_ovr | output | 1 | Parallel over-range output |
| par_clk | output | 1 | Forwarded clock for the parallel bus |
| par_oe | output | 1 | Parallel drivers enabled |

## Verification
A wrong phase count or capture point makes `cap_strobe` move, and corrupts the reassembled word within one sample period. A lane that swaps or misroutes a bit pair shows as a wrong reassembled sample in the very next period. An edge-position fault moves the observed `lane_clk` or `par_clk` edge by one or more phases in that same period. A configuration that is latched at the wrong time shows in the period being disturbed, as a changed clock, changed data or dropped enables.

// File: rtl/fmt_pkg.sv
`timescale 1ns/1ps
package fmt_pkg;

  // Configuration latched at each sample boundary.
  typedef struct packed {
    logic       par;   // 1: parallel bus, 0: bit-pair lanes
    logic       off;   // outputs disabled
    logic [2:0] rsh;   // clamped rise shift, two's complement
    logic [2:0] fsh;   // clamped fall shift, two's complement
  } fmt_cfg_t;

  // Resolve an edge field into a shift of -2..+2 steps.
  function automatic int edge_shift(input logic [2:0] field, input logic en);
    int v;
    v = int'($signed(field));
    if (!en)        return 0;
    else if (v > 2) return 2;
    else if (v < -2) return -2;
    return v;
  endfunction

  // Bring a possibly negative or overflowing step index into one period.
  function automatic int wrap_phase(input int p, input int period);
    return (p + 2 * period) % period;
  endfunction

  // A circular window [rise, fall) over the phase ring.
  function automatic logic in_window(input int ph, input int rise, input int fall);
    if (rise < fall) return (ph >= rise) && (ph < fall);
    return (ph >= rise) || (ph < fall);
  endfunction

endpackage

// File: rtl/fmt_phase.sv
`timescale 1ns/1ps
module fmt_phase #(
  parameter  int HALF = 6,
  localparam int PERIOD = 2 * HALF,
  localparam int PW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] ph,
  output logic          cap
);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                   ph_q <= ph_q + 1'b1;
  end

  assign ph  = ph_q;
  assign cap = (ph_q == LAST);

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == LAST) |=> (ph_q == '0)); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != LAST) |=> (ph_q == $past(ph_q) + 1'b1)); // R2

endmodule

// File: rtl/fmt_capture.sv
`timescale 1ns/1ps
module fmt_capture
  import fmt_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                smp_ovr,
  input  logic                strap_par,
  input  logic                cfg_mode_src,
  input  logic                cfg_par,
  input  logic                cfg_rise_en,
  input  logic [2:0]          cfg_rise_pos,
  input  logic                cfg_fall_en,
  input  logic [2:0]          cfg_fall_pos,
  input  logic                cfg_out_off,
  output logic [SAMPLE_W-1:0] held_data,
  output logic                held_ovr,
  output fmt_cfg_t            cur
);
  fmt_cfg_t next_cfg;

  always_comb begin
    next_cfg.par = cfg_mode_src ? cfg_par : strap_par;
    next_cfg.off = cfg_out_off;
    next_cfg.rsh = 3'(edge_shift(cfg_rise_pos, cfg_rise_en));
    next_cfg.fsh = 3'(edge_shift(cfg_fall_pos, cfg_fall_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_data <= '0;
      held_ovr  <= 1'b0;
      cur       <= '{par: 1'b0, off: 1'b1, rsh: 3'b000, fsh: 3'b000};
    end else if (cap) begin
      held_data <= smp_data;
      held_ovr  <= smp_ovr;
      cur       <= next_cfg;
    end
  end

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(held_data) && $stable(held_ovr) && $stable(cur))); // R10

endmodule

// File: rtl/fmt_edge.sv
`timescale 1ns/1ps
module fmt_edge
  import fmt_pkg::*;
#(
  parameter  int HALF = 6,
  localparam int PERIOD = 2 * HALF,
  localparam int PW = $clog2(PERIOD)
) (
  input  logic [PW-1:0] ph,
  input  fmt_cfg_t      cur,
  output logic          clk_hi
);
  int rise_at;
  int fall_at;

  always_comb begin
    if (cur.par) begin
      rise_at = wrap_phase(HALF + int'($signed(cur.rsh)), PERIOD);
      fall_at = wrap_phase(int'($signed(cur.fsh)), PERIOD);
    end else begin
      rise_at = wrap_phase(HALF / 2 + int'($signed(cur.rsh)), PERIOD);
      fall_at = wrap_phase(HALF + HALF / 2 + int'($signed(cur.fsh)), PERIOD);
    end
    clk_hi = in_window(int'(ph), rise_at, fall_at);
  end

endmodule

// File: rtl/fmt_lanes.sv
`timescale 1ns/1ps
module fmt_lanes #(
  parameter  int SAMPLE_W = 14,
  parameter  int HALF = 6,
  localparam int NL = SAMPLE_W / 2,
  localparam int PW = $clog2(2 * HALF)
) (
  input  logic [SAMPLE_W-1:0] held,
  input  logic [PW-1:0]       ph,
  input  logic                en,
  output logic [NL-1:0]       lanes
);
  logic odd_half;
  assign odd_half = (int'(ph) >= HALF);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign lanes[i] = en & (odd_half ? held[2*i+1] : held[2*i]);
  end

endmodule

// File: rtl/ddr_sample_fmt.sv
`timescale 1ns/1ps
module ddr_sample_fmt
  import fmt_pkg::*;
#(
  parameter  int SAMPLE_W = 14,
  parameter  int HALF = 6,
  localparam int NL = SAMPLE_W / 2,
  localparam int PW = $clog2(2 * HALF)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                smp_ovr,
  output logic                cap_strobe,
  input  logic                strap_par,
  input  logic                cfg_mode_src,
  input  logic                cfg_par,
  input  logic                cfg_rise_en,
  input  logic [2:0]          cfg_rise_pos,
  input  logic                cfg_fall_en,
  input  logic [2:0]          cfg_fall_pos,
  input  logic                cfg_out_off,
  output logic [NL-1:0]       lane_q,
  output logic                lane_clk,
  output logic                lane_oe,
  output logic [SAMPLE_W-1:0] par_q,
  output logic                par_ovr,
  output logic                par_clk,
  output logic                par_oe
);
  logic [PW-1:0]       ph;
  logic                cap;
  logic [SAMPLE_W-1:0] held_data;
  logic                held_ovr;
  fmt_cfg_t            cur;
  logic                clk_hi;
  logic                lanes_on;
  logic                bus_on;

  fmt_phase #(.HALF(HALF)) u_phase (
    .clk(clk), .rst_n(rst_n), .ph(ph), .cap(cap)
  );

  fmt_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(cap),
    .smp_data(smp_data), .smp_ovr(smp_ovr),
    .strap_par(strap_par), .cfg_mode_src(cfg_mode_src), .cfg_par(cfg_par),
    .cfg_rise_en(cfg_rise_en), .cfg_rise_pos(cfg_rise_pos),
    .cfg_fall_en(cfg_fall_en), .cfg_fall_pos(cfg_fall_pos),
    .cfg_out_off(cfg_out_off),
    .held_data(held_data), .held_ovr(held_ovr), .cur(cur)
  );

  fmt_edge #(.HALF(HALF)) u_edge (
    .ph(ph), .cur(cur), .clk_hi(clk_hi)
  );

  assign lanes_on = !cur.off && !cur.par;
  assign bus_on   = !cur.off &&  cur.par;

  fmt_lanes #(.SAMPLE_W(SAMPLE_W), .HALF(HALF)) u_lanes (
    .held(held_data), .ph(ph), .en(lanes_on), .lanes(lane_q)
  );

  assign cap_strobe = cap;
  assign lane_clk   = lanes_on & clk_hi;
  assign lane_oe    = lanes_on;
  assign par_q      = bus_on ? held_data : '0;
  assign par_ovr    = bus_on & held_ovr;
  assign par_clk    = bus_on & clk_hi;
  assign par_oe     = bus_on;

  AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lane_oe && par_oe)); // R7
  AST_EVEN_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe && $rose(lane_clk)) |-> (int'(ph) < HALF)); // R4
  AST_ODD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe && $past(lane_oe) && $fell(lane_clk)) |-> (int'(ph) >= HALF)); // R4
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (par_oe && ph != '0) |-> ($stable(par_q) && $stable(par_ovr))); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_oe && !par_oe) |-> (lane_q == '0 && !lane_clk && par_q == '0 && !par_clk)); // R9

endmodule

// File: tb/tb_ddr_sample_fmt.sv
`timescale 1ns/1ps
module tb_ddr_sample_fmt;
  localparam int W = 14;
  localparam int H = 6;
  localparam int P = 2 * H;
  localparam int NL = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic smp_ovr = 1'b0, strap_par = 1'b0, cfg_mode_src = 1'b0, cfg_par = 1'b0;
  logic cfg_rise_en = 1'b0, cfg_fall_en = 1'b0, cfg_out_off = 1'b0;
  logic [2:0] cfg_rise_pos = '0, cfg_fall_pos = '0;
  logic cap_strobe, lane_clk, lane_oe, par_ovr, par_clk, par_oe;
  logic [NL-1:0] lane_q;
  logic [W-1:0] par_q;

  always #2.5 clk = ~clk;

  ddr_sample_fmt dut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_ovr(smp_ovr),
    .cap_strobe(cap_strobe), .strap_par(strap_par), .cfg_mode_src(cfg_mode_src),
    .cfg_par(cfg_par), .cfg_rise_en(cfg_rise_en), .cfg_rise_pos(cfg_rise_pos),
    .cfg_fall_en(cfg_fall_en), .cfg_fall_pos(cfg_fall_pos), .cfg_out_off(cfg_out_off),
    .lane_q(lane_q), .lane_clk(lane_clk), .lane_oe(lane_oe),
    .par_q(par_q), .par_ovr(par_ovr), .par_clk(par_clk), .par_oe(par_oe)
  );

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  // Fields: data14 ovr src cfgpar strap off ren rpos3 fen fpos3 = 27 bits
  localparam int NV = 9;
  localparam logic [26:0] VEC [NV] = '{
    {14'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 3'b000},
    {14'h2AAA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b010, 1'b1, 3'b110},
    {14'h1555, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, 3'b001},
    {14'h0ABC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b100, 1'b1, 3'b011},
    {14'h3FFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 3'b000},
    {14'h0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b010, 1'b1, 3'b111},
    {14'h2001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 3'b000},
    {14'h3ABC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0, 3'b000},
    {14'h0F0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010, 1'b0, 3'b101}
  };

  logic [NL-1:0] o_lq [P];
  logic [W-1:0]  o_pq [P];
  logic o_lc [P], o_pc [P], o_loe [P], o_poe [P], o_po [P], o_cap [P];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Shift table written as a lookup over the 3-bit code.
  function automatic int shift_of(input logic [2:0] code, input logic en);
    if (!en) return 0;
    case (code)
      3'b001: return 1;
      3'b010, 3'b011: return 2;
      3'b111: return -1;
      3'b100, 3'b101, 3'b110: return -2;
      default: return 0;
    endcase
  endfunction

  function automatic int find_edge(input bit want_rise, input bit is_par);
    for (int k = 0; k < P; k++) begin
      int pk;
      logic a, b;
      pk = (k + P - 1) % P;
      a = is_par ? o_pc[pk] : o_lc[pk];
      b = is_par ? o_pc[k]  : o_lc[k];
      if (want_rise && !a && b) return k;
      if (!want_rise && a && !b) return k;
    end
    return -1;
  endfunction

  // Called at the negedge of a cap_strobe phase; drives, then records one period.
  task automatic run_period(input logic [26:0] v, input bit disturb);
    {smp_data, smp_ovr, cfg_mode_src, cfg_par, strap_par, cfg_out_off,
     cfg_rise_en, cfg_rise_pos, cfg_fall_en, cfg_fall_pos} = v;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      if (disturb && k == 3) begin
        smp_data = ~smp_data; cfg_out_off = 1'b1; cfg_par = ~cfg_par;
        cfg_mode_src = 1'b1; cfg_rise_en = 1'b1; cfg_rise_pos = 3'b010;
      end
      o_lq[k] = lane_q; o_pq[k] = par_q; o_lc[k] = lane_clk; o_pc[k] = par_clk;
      o_loe[k] = lane_oe; o_poe[k] = par_oe; o_po[k] = par_ovr; o_cap[k] = cap_strobe;
    end
  endtask

  task automatic check_period(input logic [26:0] v, input string tag);
    logic [W-1:0] d; logic ovr, src, cp, st, off, re, fe; logic [2:0] rp, fp;
    bit par, ok;
    int rs, fs, er, ef, gr, gf;
    logic [W-1:0] rx;
    {d, ovr, src, cp, st, off, re, rp, fe, fp} = v;
    par = src ? cp : st;
    rs = shift_of(rp, re); fs = shift_of(fp, fe);
    ok = 1'b1;
    for (int k = 0; k < P; k++) ok &= (o_cap[k] == (k == P - 1));
    chk(ok, "R2", {tag, " cap_strobe only in last phase"}, 0, 0);
    if (off) begin
      ok = 1'b1;
      for (int k = 0; k < P; k++)
        ok &= !o_loe[k] && !o_poe[k] && o_lq[k] == '0 && o_pq[k] == '0 && !o_lc[k] && !o_pc[k] && !o_po[k];
      chk(ok, "R9", {tag, " outputs quiet when off"}, int'(o_loe[0]), 0);
      return;
    end
    if (!par) begin
      ok = 1'b1;
      for (int k = 0; k < P; k++) ok &= o_loe[k] && !o_poe[k] && o_pq[k] == '0 && !o_pc[k] && !o_po[k];
      chk(ok, "R3", {tag, " lane mode enables and idle bus"}, int'(o_poe[0]), 0);
      er = (H / 2 + rs + P) % P; ef = (H + H / 2 + fs + P) % P;
      gr = find_edge(1'b1, 1'b0); gf = find_edge(1'b0, 1'b0);
      chk(gr == er, (rs != 0) ? "R5" : "R4", {tag, " lane clock rise phase"}, gr, er);
      chk(gf == ef, (fs != 0) ? "R6" : "R4", {tag, " lane clock fall phase"}, gf, ef);
      rx = '0;
      if (gr >= 0 && gf >= 0)
        for (int i = 0; i < NL; i++) begin
          rx[2*i]   = o_lq[gr][i];
          rx[2*i+1] = o_lq[gf][i];
        end
      chk(rx == d, "R3", {tag, " reassembled sample"}, int'(rx), int'(d));
    end else begin
      ok = 1'b1;
      for (int k = 0; k < P; k++)
        ok &= o_poe[k] && !o_loe[k] && o_pq[k] == d && o_po[k] == ovr && o_lq[k] == '0 && !o_lc[k];
      chk(ok, (src ? "R7" : "R8"), {tag, " parallel bus data and ovr"}, int'(o_pq[0]), int'(d));
      er = (H + rs + P) % P; ef = (fs + P) % P;
      gr = find_edge(1'b1, 1'b1); gf = find_edge(1'b0, 1'b1);
      chk(gr == er && gf == ef, "R7", {tag, " parallel clock edges"}, gr * 16 + gf, er * 16 + ef);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    smp_data = 14'h3FFF; cfg_mode_src = 1'b1; cfg_par = 1'b1;
    // R1: first period after reset stays quiet
    ok = 1'b1;
    for (int k = 0; k < P - 2; k++) begin
      @(negedge clk);
      ok &= !lane_oe && !par_oe && lane_q == '0 && par_q == '0 && !lane_clk && !par_clk && !par_ovr;
    end
    chk(ok, "R1", "quiet outputs before first boundary", int'(par_q), 0);
    while (!cap_strobe) @(negedge clk);
    for (int n = 0; n < NV; n++) begin
      run_period(VEC[n], 1'b0);
      check_period(VEC[n], $sformatf("vec%0d", n));
    end
    // R10: mid-period disturbance leaves the running period untouched
    run_period(VEC[0], 1'b1);
    check_period(VEC[0], "R10 disturbed");
    run_period(VEC[2], 1'b0);
    check_period(VEC[2], "R10 recovered");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule